// File: doc/BRIEF.md
# Multicycle Accumulator Machine Controller

This block sequences a 16-bit accumulator machine through fetch, decode and execute. Each register transfer takes its own controller state. Every instruction word has a 4-bit operation code in bits 15:12 and a 12-bit address field in bits 11:0. The controller drives the load enables of six registers:

- the accumulator
- the memory address register
- the memory buffer register
- the program counter
- the instruction register
- an input holding register

It also drives the source select of one shared transfer bus, an add enable and the memory write strobe.

The project also contains a small register datapath and a word-addressed memory with a combinational read and a clocked write, so that the controller can be exercised on its own. The memory holds 2^MEM_AW words. Addresses outside that range read as zero, and writes to them are dropped.

A loader port fills memory, normally while reset is held. The loader has priority over a machine write in the same cycle. A second read port lets the surroundings inspect any memory word. The accumulator, the program counter and a halt flag are brought out.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low, `ac_out` and `pc_out` are 0 and `halted` is 0. After release, execution starts at address 0.
- R2: Load X (code 1) sets AC to M[X]. Add X (code 3) sets AC to (AC + M[X]) mod 2^16.
- R3: Store X (code 2) writes AC into M[X].
- R4: Input (code 5) captures `in_value` into the input holding register and then copies it into AC.
- R5: LoadI X (code D) reads a pointer P from M[X] and then sets AC to M[P]. M[X] is not changed.
- R6: StoreI X (code E) reads a pointer P from M[X] and then writes AC into M[P]. M[X] is not changed.
- R7: SkipCond (code 8) reads a condition code from bits 11:10 and skips the next word when the condition holds. The codes are:
  - 00: AC is negative (bit 15 set).
  - 01: AC is zero.
  - 10: AC is positive (nonzero with bit 15 clear).
  - 11: never skips.
- R8: Jump X (code 9) sets PC to X.
- R9: Halt (code 7) raises `halted`. The machine then stays in that state until reset, with PC and AC frozen; PC holds the halt address plus one.
- R10: The operation codes 0, 4, 6, A, B, C and F change neither AC nor memory, and execution continues with the next word.
- R11: Every instruction has a fixed length. Fetch and decode take 3 cycles. The execute phase then takes:
  - 2 cycles for Load, Add, Store and Input.
  - 1 cycle for Jump and SkipCond.
  - 4 cycles for LoadI and StoreI.
  - 0 cycles for unused codes.
  The fetch increments PC by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_value | input | 16 | External value taken by Input |
| load_we | input | 1 | Loader write strobe |
| load_addr | input | 8 | Loader word address |
| load_data | input | 16 | Loader write data |
| peek_addr | input | 8 | Inspection read address |
| peek_data | output | 16 | Memory word at `peek_addr` |
| ac_out | output | 16 | Accumulator |
| pc_out | output | 12 | Program counter |
| halted | output | 1 | High while parked in the halt state |

## Verification
A controller that branches to the wrong state after decode shows up within one instruction, in one of two ways. Either the halt arrives a different number of cycles after reset, or AC or a memory word holds the wrong value once the machine parks. Each program therefore ends in Halt, and the bench checks the cycle count as well as the final AC, PC and memory contents. Small, flag-sized faults are caught by two kinds of program. The skip cases take each condition code against a value that meets it and a value that does not; a faulty condition decode changes which of two distinct markers ends in AC. The indirect cases place pointer and target in separate words, so that taking the wrong address pass writes or reads the wrong word.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
    parameter int DATA_W = 16;
    parameter int ADDR_W = 12;
    parameter int OP_W   = 4;
    parameter int COND_W = 2;
    parameter int MEM_AW = 8;

    localparam logic [OP_W-1:0] OPC_LOAD   = 4'h1;
    localparam logic [OP_W-1:0] OPC_STORE  = 4'h2;
    localparam logic [OP_W-1:0] OPC_ADD    = 4'h3;
    localparam logic [OP_W-1:0] OPC_INPUT  = 4'h5;
    localparam logic [OP_W-1:0] OPC_HALT   = 4'h7;
    localparam logic [OP_W-1:0] OPC_SKIP   = 4'h8;
    localparam logic [OP_W-1:0] OPC_JUMP   = 4'h9;
    localparam logic [OP_W-1:0] OPC_LOADI  = 4'hD;
    localparam logic [OP_W-1:0] OPC_STOREI = 4'hE;

    typedef enum logic [4:0] {
        S_F0, S_F1, S_DEC,
        S_LD0, S_LD1, S_AD0, S_AD1, S_ST0, S_ST1, S_IN0, S_IN1,
        S_SK0, S_JP0,
        S_LI0, S_LI1, S_LI2, S_LI3,
        S_SI0, S_SI1, S_SI2, S_SI3,
        S_HALT
    } state_e;

    typedef enum logic [2:0] {
        BUS_NONE, BUS_PC, BUS_MEM, BUS_IRADR, BUS_MBR, BUS_AC, BUS_EXT, BUS_INREG
    } bus_sel_e;

    typedef struct packed {
        logic     ld_ac;
        logic     alu_add;
        logic     ld_mar;
        logic     ld_mbr;
        logic     ld_pc;
        logic     inc_pc;
        logic     ld_ir;
        logic     ld_in;
        logic     mem_we;
        bus_sel_e bus_sel;
    } ctl_t;
endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [MEM_AW-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [DATA_W-1:0] mem_q [DEPTH];
    logic              wr_in_range;
    logic              rd_in_range;

    assign wr_in_range = (waddr[ADDR_W-1:MEM_AW] == '0);
    assign rd_in_range = (raddr_a[ADDR_W-1:MEM_AW] == '0);

    always_ff @(posedge clk) begin
        if (we && wr_in_range) begin
            mem_q[waddr[MEM_AW-1:0]] <= wdata;
        end
    end

    assign rdata_a = rd_in_range ? mem_q[raddr_a[MEM_AW-1:0]] : '0;
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/acc_cpu_datapath.sv
module acc_cpu_datapath
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_t              ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] ext_in,
    output logic [ADDR_W-1:0] mar,
    output logic [ADDR_W-1:0] pc,
    output logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] ac,
    output logic [OP_W-1:0]   opcode,
    output logic [COND_W-1:0] cond,
    output logic              ac_neg,
    output logic              ac_zero
);
    localparam int PAD_W = DATA_W - ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0] ac;
        logic [DATA_W-1:0] mbr;
        logic [DATA_W-1:0] inreg;
        logic [DATA_W-1:0] ir;
        logic [ADDR_W-1:0] mar;
        logic [ADDR_W-1:0] pc;
    } regs_t;

    regs_t             r_d, r_q;
    logic [DATA_W-1:0] bus;

    always_comb begin
        unique case (ctl.bus_sel)
            BUS_PC:    bus = {{PAD_W{1'b0}}, r_q.pc};
            BUS_MEM:   bus = mem_rdata;
            BUS_IRADR: bus = {{PAD_W{1'b0}}, r_q.ir[ADDR_W-1:0]};
            BUS_MBR:   bus = r_q.mbr;
            BUS_AC:    bus = r_q.ac;
            BUS_EXT:   bus = ext_in;
            BUS_INREG: bus = r_q.inreg;
            default:   bus = '0;
        endcase
    end

    always_comb begin
        r_d = r_q;
        if (ctl.ld_ac)  r_d.ac    = ctl.alu_add ? (r_q.ac + r_q.mbr) : bus;
        if (ctl.ld_mbr) r_d.mbr   = bus;
        if (ctl.ld_in)  r_d.inreg = bus;
        if (ctl.ld_ir)  r_d.ir    = bus;
        if (ctl.ld_mar) r_d.mar   = bus[ADDR_W-1:0];
        if (ctl.ld_pc)  r_d.pc    = bus[ADDR_W-1:0];
        else if (ctl.inc_pc) r_d.pc = r_q.pc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mar     = r_q.mar;
    assign pc      = r_q.pc;
    assign mbr     = r_q.mbr;
    assign ac      = r_q.ac;
    assign opcode  = r_q.ir[DATA_W-1 -: OP_W];
    assign cond    = r_q.ir[ADDR_W-1 -: COND_W];
    assign ac_neg  = r_q.ac[DATA_W-1];
    assign ac_zero = (r_q.ac == '0);

    // R3, R6: a memory write always carries the current accumulator
    a_r3_write_data_is_ac: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.mem_we |-> (r_q.mbr == r_q.ac));

    // R11: the instruction fetch advances PC by exactly one
    a_r11_fetch_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_ir |=> (r_q.pc == ADDR_W'($past(r_q.pc) + 1'b1)));
endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   opcode,
    input  logic [COND_W-1:0] cond,
    input  logic              ac_neg,
    input  logic              ac_zero,
    output ctl_t              ctl,
    output logic              halted
);
    state_e state_d, state_q;
    logic   skip_hit;

    always_comb begin
        unique case (cond)
            2'b00:   skip_hit = ac_neg;
            2'b01:   skip_hit = ac_zero;
            2'b10:   skip_hit = !ac_neg && !ac_zero;
            default: skip_hit = 1'b0;
        endcase
    end

    always_comb begin
        state_d = state_q;
        ctl     = '0;
        unique case (state_q)
            S_F0:  begin ctl.bus_sel = BUS_PC;    ctl.ld_mar = 1'b1; state_d = S_F1; end
            S_F1:  begin ctl.bus_sel = BUS_MEM;   ctl.ld_ir = 1'b1; ctl.inc_pc = 1'b1; state_d = S_DEC; end
            S_DEC: begin
                ctl.bus_sel = BUS_IRADR;
                ctl.ld_mar  = 1'b1;
                unique case (opcode)
                    OPC_LOAD:   state_d = S_LD0;
                    OPC_STORE:  state_d = S_ST0;
                    OPC_ADD:    state_d = S_AD0;
                    OPC_INPUT:  state_d = S_IN0;
                    OPC_HALT:   state_d = S_HALT;
                    OPC_SKIP:   state_d = S_SK0;
                    OPC_JUMP:   state_d = S_JP0;
                    OPC_LOADI:  state_d = S_LI0;
                    OPC_STOREI: state_d = S_SI0;
                    default:    state_d = S_F0;
                endcase
            end
            S_LD0: begin ctl.bus_sel = BUS_MEM;   ctl.ld_mbr = 1'b1; state_d = S_LD1; end
            S_LD1: begin ctl.bus_sel = BUS_MBR;   ctl.ld_ac  = 1'b1; state_d = S_F0;  end
            S_AD0: begin ctl.bus_sel = BUS_MEM;   ctl.ld_mbr = 1'b1; state_d = S_AD1; end
            S_AD1: begin ctl.alu_add = 1'b1;      ctl.ld_ac  = 1'b1; state_d = S_F0;  end
            S_ST0: begin ctl.bus_sel = BUS_AC;    ctl.ld_mbr = 1'b1; state_d = S_ST1; end
            S_ST1: begin ctl.mem_we  = 1'b1;                         state_d = S_F0;  end
            S_IN0: begin ctl.bus_sel = BUS_EXT;   ctl.ld_in  = 1'b1; state_d = S_IN1; end
            S_IN1: begin ctl.bus_sel = BUS_INREG; ctl.ld_ac  = 1'b1; state_d = S_F0;  end
            S_SK0: begin ctl.inc_pc  = skip_hit;                     state_d = S_F0;  end
            S_JP0: begin ctl.bus_sel = BUS_IRADR; ctl.ld_pc  = 1'b1; state_d = S_F0;  end
            S_LI0: begin ctl.bus_sel = BUS_MEM;   ctl.ld_mbr = 1'b1; state_d = S_LI1; end
            S_LI1: begin ctl.bus_sel = BUS_MBR;   ctl.ld_mar = 1'b1; state_d = S_LI2; end
            S_LI2: begin ctl.bus_sel = BUS_MEM;   ctl.ld_mbr = 1'b1; state_d = S_LI3; end
            S_LI3: begin ctl.bus_sel = BUS_MBR;   ctl.ld_ac  = 1'b1; state_d = S_F0;  end
            S_SI0: begin ctl.bus_sel = BUS_MEM;   ctl.ld_mbr = 1'b1; state_d = S_SI1; end
            S_SI1: begin ctl.bus_sel = BUS_MBR;   ctl.ld_mar = 1'b1; state_d = S_SI2; end
            S_SI2: begin ctl.bus_sel = BUS_AC;    ctl.ld_mbr = 1'b1; state_d = S_SI3; end
            S_SI3: begin ctl.mem_we  = 1'b1;                         state_d = S_F0;  end
            S_HALT: state_d = S_HALT;
            default: state_d = S_F0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_F0;
        else        state_q <= state_d;
    end

    assign halted = (state_q == S_HALT);

    // Checker: cycles spent since the last fetch start
    logic [3:0] len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 len_q <= '0;
        else if (state_d == S_F0)   len_q <= '0;
        else if (state_q != S_HALT) len_q <= len_q + 1'b1;
    end

    // R11: no instruction runs longer than fetch plus four execute states
    a_r11_bounded_length: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_HALT) |-> (len_q <= 4'd6));

    // R9: the halt state is left only through reset
    a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT) |=> (state_q == S_HALT));
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_value,
    input  logic              load_we,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [DATA_W-1:0] load_data,
    input  logic [MEM_AW-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [DATA_W-1:0] ac_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic              halted
);
    ctl_t              ctl;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;
    logic [DATA_W-1:0] mem_rdata;
    logic [OP_W-1:0]   opcode;
    logic [COND_W-1:0] cond;
    logic              ac_neg, ac_zero;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    assign wr_en   = load_we || ctl.mem_we;
    assign wr_addr = load_we ? {{(ADDR_W-MEM_AW){1'b0}}, load_addr} : mar;
    assign wr_data = load_we ? load_data : mbr;

    acc_cpu_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (opcode),
        .cond    (cond),
        .ac_neg  (ac_neg),
        .ac_zero (ac_zero),
        .ctl     (ctl),
        .halted  (halted)
    );

    acc_cpu_datapath u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .ext_in    (in_value),
        .mar       (mar),
        .pc        (pc_out),
        .mbr       (mbr),
        .ac        (ac_out),
        .opcode    (opcode),
        .cond      (cond),
        .ac_neg    (ac_neg),
        .ac_zero   (ac_zero)
    );

    acc_cpu_mem u_mem (
        .clk     (clk),
        .we      (wr_en),
        .waddr   (wr_addr),
        .wdata   (wr_data),
        .raddr_a (mar),
        .rdata_a (mem_rdata),
        .raddr_b (peek_addr),
        .rdata_b (peek_data)
    );

    // R9: once halted, the visible machine state is frozen
    a_r9_frozen_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(pc_out) && $stable(ac_out)));
endmodule

// File: tb/acc_cpu_core_tb_top.sv
module acc_cpu_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] in_value = '0;
    logic        load_we = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [15:0] load_data = '0;
    logic [7:0]  peek_addr = '0;
    logic [15:0] peek_data;
    logic [15:0] ac_out;
    logic [11:0] pc_out;
    logic        halted;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    acc_cpu_core dut_i (
        .clk(clk), .rst_n(rst_n), .in_value(in_value),
        .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .ac_out(ac_out), .pc_out(pc_out), .halted(halted)
    );

    function automatic logic [15:0] ins(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [15:0] d);
        @(negedge clk);
        load_we = 1'b1; load_addr = 8'(a); load_data = d;
        @(negedge clk);
        load_we = 1'b0;
    endtask

    task automatic peek(input int a, output logic [15:0] d);
        peek_addr = 8'(a);
        #1;
        d = peek_data;
    endtask

    task automatic hold_reset();
        @(negedge clk);
        rst_n = 1'b0;
    endtask

    task automatic run(output int cycles);
        @(negedge clk);
        rst_n = 1'b1;
        cycles = 0;
        while (!halted && cycles < 1000) begin
            @(negedge clk);
            cycles++;
        end
    endtask

    task automatic t_load_add();
        int cyc;
        hold_reset();
        put(0, ins(4'h1, 12'h020));
        put(1, ins(4'h3, 12'h021));
        put(2, ins(4'h7, 12'h000));
        put(32, 16'h1234);
        put(33, 16'hF000);
        run(cyc);
        check("R2 load+add wrap", ac_out, 16'h0234);
        check("R11 load/add cycles", cyc, 13);
        check("R9 pc after halt", pc_out, 12'h003);
        in_value = 16'h5555;
        repeat (5) @(negedge clk);
        check("R9 still halted", halted, 1'b1);
        check("R9 pc frozen", pc_out, 12'h003);
        check("R9 ac frozen", ac_out, 16'h0234);
    endtask

    task automatic t_reset();
        hold_reset();
        #1;
        check("R1 reset ac", ac_out, 16'h0000);
        check("R1 reset pc", pc_out, 12'h000);
        check("R1 reset halted", halted, 1'b0);
    endtask

    task automatic t_input_store();
        int cyc;
        logic [15:0] w;
        hold_reset();
        in_value = 16'hBEEF;
        put(0, ins(4'h5, 12'h000));
        put(1, ins(4'h2, 12'h030));
        put(2, ins(4'h7, 12'h000));
        put(48, 16'h0000);
        run(cyc);
        check("R4 input to ac", ac_out, 16'hBEEF);
        peek(48, w);
        check("R3 store word", w, 16'hBEEF);
        check("R11 input/store cycles", cyc, 13);
    endtask

    task automatic t_indirect();
        int cyc;
        logic [15:0] w;
        hold_reset();
        put(0, ins(4'hD, 12'h040));
        put(1, ins(4'hE, 12'h041));
        put(2, ins(4'h7, 12'h000));
        put(64, 16'h0050);
        put(65, 16'h0060);
        put(80, 16'h7777);
        put(96, 16'h0000);
        run(cyc);
        check("R5 loadi ac", ac_out, 16'h7777);
        peek(96, w);
        check("R6 storei target", w, 16'h7777);
        peek(65, w);
        check("R6 storei pointer kept", w, 16'h0060);
        peek(64, w);
        check("R5 loadi pointer kept", w, 16'h0050);
        check("R11 indirect cycles", cyc, 17);
    endtask

    task automatic t_skip(input logic [15:0] v, input logic [1:0] cc, input bit exp_skip);
        int cyc;
        hold_reset();
        put(0, ins(4'h1, 12'h020));
        put(1, {4'h8, cc, 10'h000});
        put(2, ins(4'h1, 12'h021));
        put(3, ins(4'h7, 12'h000));
        put(32, v);
        put(33, 16'hAAAA);
        run(cyc);
        check($sformatf("R7 skip cc=%0d v=%0h ac", cc, v), ac_out, exp_skip ? v : 16'hAAAA);
        check($sformatf("R11 skip cc=%0d cycles", cc), cyc, exp_skip ? 12 : 17);
    endtask

    task automatic t_jump();
        int cyc;
        hold_reset();
        put(0, ins(4'h9, 12'h010));
        put(1, ins(4'h1, 12'h021));
        put(2, ins(4'h7, 12'h000));
        put(16, ins(4'h1, 12'h020));
        put(17, ins(4'h7, 12'h000));
        put(32, 16'h1111);
        put(33, 16'hAAAA);
        run(cyc);
        check("R8 jump target ac", ac_out, 16'h1111);
        check("R8 jump pc", pc_out, 12'h012);
        check("R11 jump cycles", cyc, 12);
    endtask

    task automatic t_unused();
        int cyc;
        logic [15:0] w;
        hold_reset();
        put(0, ins(4'h1, 12'h020));
        put(1, ins(4'h4, 12'h020));
        put(2, ins(4'h6, 12'h020));
        put(3, ins(4'hF, 12'h020));
        put(4, ins(4'h7, 12'h000));
        put(32, 16'h4242);
        run(cyc);
        check("R10 unused ac kept", ac_out, 16'h4242);
        peek(32, w);
        check("R10 unused mem kept", w, 16'h4242);
        check("R10 unused pc", pc_out, 12'h005);
        check("R11 unused cycles", cyc, 17);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        report();
    end

    initial begin
        t_reset();
        t_load_add();
        t_reset();
        t_input_store();
        t_indirect();
        t_skip(16'h8001, 2'b00, 1'b1);
        t_skip(16'h0000, 2'b00, 1'b0);
        t_skip(16'h0000, 2'b01, 1'b1);
        t_skip(16'h0005, 2'b01, 1'b0);
        t_skip(16'h0005, 2'b10, 1'b1);
        t_skip(16'h8000, 2'b10, 1'b0);
        t_skip(16'h0000, 2'b10, 1'b0);
        t_skip(16'h0000, 2'b11, 1'b0);
        t_skip(16'h8000, 2'b11, 1'b0);
        t_jump();
        t_unused();
        report();
    end
endmodule